// File: doc/BRIEF.md
# Buck Converter Start-up and Fault Supervisor

This block is the digital supervisor of a synchronous buck regulator. It turns a three-level enable into a working mode: off, forced continuous PWM or light-load auto-skip. On start-up it raises the reference code for the error-amplifier DAC from zero to its target value. It also applies the fault policy. Its inputs are single-bit flags from analog comparators. Its outputs are a run permission, a mode select, the reference code and override commands for the gate drivers and the output discharge switch.

Faults are handled in two ways. Over-voltage on the feedback input and an absolute output over-voltage override the gates only while the flag is present. Supply under-voltage and over-temperature stop the converter until the flag clears, and the ramp then starts again from zero. An under-voltage on the feedback is blanked during start-up. After blanking, it must last for a set number of cycles, and it then latches the converter off. Only a low enable or a supply under-voltage releases that latch.

Top module: `buck_supervisor`

## Requirements
- R1: Enable decode. With `en_gt_low`=0 the block is off (`run`=0, `skip_mode`=0), whatever `en_gt_high` is. With `en_gt_low`=1 and `en_gt_high`=0 it runs in forced PWM (`skip_mode`=0). With both at 1 it runs in auto-skip (`skip_mode`=1).
- R2: While `run`=0, `ref_code` is 0. While `run`=1, `ref_code` rises by exactly one every STEP_CYCLES clock cycles until it reaches TARGET_CODE, and then holds.
- R3: While running, `fb_over`=1 gives `hs_force_off`=1, `ls_force_on`=1, `ls_force_off`=0 and `discharge`=1 in the same cycle. These outputs return to normal when the flag drops.
- R4: While running with `fb_over`=0, `vout_over`=1 sets only `hs_force_off`=1. `ls_force_on`, `ls_force_off` and `discharge` stay 0.
- R5: Once armed, if `fb_under` is sampled high on UV_DELAY consecutive clock edges, the block latches off. It then holds `run`=0, `hs_force_off`=1, `ls_force_off`=1, `ls_force_on`=0 and `discharge`=1, and these stay after `fb_under` falls.
- R6: A `fb_under` burst shorter than UV_DELAY edges has no effect, and each new burst counts from zero again.
- R7: `fb_under` is ignored for the first BLANK_CYCLES clock edges of every run interval.
- R8: `supply_low` or `temp_high` forces `run`=0, both gates off (`hs_force_off`=1, `ls_force_off`=1) and `discharge`=1. When the flag clears, the block runs again without any other action.
- R9: `temp_high` does not release the under-voltage latch. Only `en_gt_low`=0 or `supply_low`=1 releases it.
- R10: `discharge`=1 and both gates are held off whenever the enable decodes as off.
- R11: Each new run interval (after disable, a lockout, over-temperature or a released latch) restarts the reference ramp from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_gt_low | input | 1 | Enable pin is above the low threshold |
| en_gt_high | input | 1 | Enable pin is above the high threshold |
| fb_over | input | 1 | Feedback is above the over-voltage threshold |
| fb_under | input | 1 | Feedback is below the under-voltage threshold |
| vout_over | input | 1 | Output is above its absolute limit |
| supply_low | input | 1 | Bias supply is below its lockout level |
| temp_high | input | 1 | Die over-temperature |
| run | output | 1 | Switching sequencer may operate |
| skip_mode | output | 1 | Auto-skip selected (0 = forced PWM) |
| ref_code | output | DAC_W | Soft-start reference code |
| hs_force_off | output | 1 | Force high-side gate off |
| ls_force_on | output | 1 | Force low-side gate on |
| ls_force_off | output | 1 | Force low-side gate off |
| discharge | output | 1 | Output discharge switch on |

## Verification
The hardest state to reach is a latched under-voltage that is then hit by over-temperature and later released by a supply lockout. Reaching it needs a full blanking interval, then an unbroken `fb_under` burst of exactly the right length, then a chosen order of fault flags. Directed phases build that order step by step, including bursts one cycle short of the delay. Random stimulus with long `fb_under` bursts and rare enable and fault toggles then visits the same corners in other orders, and a per-cycle bench model checks every output.

// File: rtl/buck_sup_pkg.sv
package buck_sup_pkg;
  typedef enum logic [1:0] {MODE_OFF = 2'd0, MODE_PWM = 2'd1, MODE_SKIP = 2'd2} op_mode_t;

  // Three-level enable from two threshold flags; an inconsistent pair reads as off.
  function automatic op_mode_t decode_enable(input logic gt_low, input logic gt_high);
    if (!gt_low)      return MODE_OFF;
    else if (gt_high) return MODE_SKIP;
    else              return MODE_PWM;
  endfunction

  // Clock cycles from start to the full reference code.
  function automatic int unsigned ramp_cycles(input int unsigned target, input int unsigned step);
    return target * step;
  endfunction
endpackage

// File: rtl/sup_ref_ramp.sv
module sup_ref_ramp #(
  parameter int unsigned DAC_W       = 10,
  parameter int unsigned TARGET_CODE = 600,
  parameter int unsigned STEP_CYCLES = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  output logic [DAC_W-1:0] code
);
  localparam logic [DAC_W-1:0] TOP = DAC_W'(TARGET_CODE);

  logic tick;
  logic at_top;
  assign at_top = (code == TOP);

  generate
    if (STEP_CYCLES > 1) begin : g_div
      localparam int unsigned CW = $clog2(STEP_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);
      logic [CW-1:0] div;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  div <= '0;
        else if (!active || at_top)  div <= '0;
        else if (div == LAST)        div <= '0;
        else                         div <= div + 1'b1;
      end
      assign tick = (div == LAST);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    code <= '0;
    else if (!active)              code <= '0;
    else if (!at_top && tick)      code <= code + 1'b1;
  end

  p_ref_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (code == '0));
  p_ref_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (code == $past(code) || code == $past(code) + 1'b1));
  p_ref_ceiling_r2: assert property (@(posedge clk) disable iff (!rst_n)
    code <= TOP);
endmodule

// File: rtl/sup_uv_guard.sv
module sup_uv_guard #(
  parameter int unsigned BLANK_CYCLES = 200000,
  parameter int unsigned UV_DELAY     = 3200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic clear,
  input  logic fb_under,
  output logic armed,
  output logic latched
);
  localparam int unsigned BW = $clog2(BLANK_CYCLES + 1);
  localparam int unsigned UW = $clog2(UV_DELAY + 1);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYCLES);
  localparam logic [UW-1:0] UV_LAST   = UW'(UV_DELAY - 1);

  logic [BW-1:0] blank_cnt;
  logic [UW-1:0] uv_cnt;
  logic          uv_qual;
  logic          uv_expire;

  assign armed     = (blank_cnt == BLANK_END);
  assign uv_qual   = active && armed && fb_under;
  assign uv_expire = uv_qual && (uv_cnt == UV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_cnt <= '0;
      uv_cnt    <= '0;
      latched   <= 1'b0;
    end else begin
      if (!active)     blank_cnt <= '0;
      else if (!armed) blank_cnt <= blank_cnt + 1'b1;

      if (!uv_qual)              uv_cnt <= '0;
      else if (uv_cnt != UV_LAST) uv_cnt <= uv_cnt + 1'b1;

      if (clear)          latched <= 1'b0;
      else if (uv_expire) latched <= 1'b1;
    end
  end

  p_uv_blanked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !latched) |=> !latched);
  p_uv_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!latched && !fb_under) |=> !latched);
  p_uv_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !clear) |=> latched);
endmodule

// File: rtl/buck_supervisor.sv
module buck_supervisor
  import buck_sup_pkg::*;
#(
  parameter int unsigned DAC_W        = 10,
  parameter int unsigned TARGET_CODE  = 600,
  parameter int unsigned STEP_CYCLES  = 200,
  parameter int unsigned BLANK_CYCLES = 200000,
  parameter int unsigned UV_DELAY     = 3200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_gt_low,
  input  logic             en_gt_high,
  input  logic             fb_over,
  input  logic             fb_under,
  input  logic             vout_over,
  input  logic             supply_low,
  input  logic             temp_high,
  output logic             run,
  output logic             skip_mode,
  output logic [DAC_W-1:0] ref_code,
  output logic             hs_force_off,
  output logic             ls_force_on,
  output logic             ls_force_off,
  output logic             discharge
);
  op_mode_t mode;
  logic     enabled;
  logic     active;
  logic     latch_clear;
  logic     uv_armed;
  logic     uv_latched;

  assign mode        = decode_enable(en_gt_low, en_gt_high);
  assign enabled     = (mode != MODE_OFF);
  assign latch_clear = !enabled || supply_low;
  assign active      = enabled && !supply_low && !temp_high && !uv_latched;

  sup_ref_ramp #(
    .DAC_W(DAC_W), .TARGET_CODE(TARGET_CODE), .STEP_CYCLES(STEP_CYCLES)
  ) i_ramp (
    .clk(clk), .rst_n(rst_n), .active(active), .code(ref_code)
  );

  sup_uv_guard #(
    .BLANK_CYCLES(BLANK_CYCLES), .UV_DELAY(UV_DELAY)
  ) i_uv (
    .clk(clk), .rst_n(rst_n), .active(active), .clear(latch_clear),
    .fb_under(fb_under), .armed(uv_armed), .latched(uv_latched)
  );

  assign run          = active;
  assign skip_mode    = active && (mode == MODE_SKIP);
  assign hs_force_off = !active || fb_over || vout_over;
  assign ls_force_on  = active && fb_over;
  assign ls_force_off = !active;
  assign discharge    = !active || fb_over;

  p_gate_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_force_on && ls_force_off));
  p_ovp_action_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && !supply_low && !temp_high && !uv_latched && fb_over)
      |-> (hs_force_off && ls_force_on && discharge));
  p_nonlatched_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_low || temp_high) |-> (!run && hs_force_off && ls_force_off && discharge));
  p_disabled_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_gt_low |-> (!run && !skip_mode && discharge && ls_force_off));
  p_restart_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (ref_code == '0));
endmodule

// File: tb/test_buck_supervisor.sv
module test_buck_supervisor;
  localparam int DW = 6, TGT = 12, STEP = 3, BLANK = 30, UVD = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lo = 0, hi = 0, ov = 0, uv = 0, vh = 0, sl = 0, th = 0;
  logic run, skip, hs_off, ls_on, ls_off, dis;
  logic [DW-1:0] ref_code;

  always #5 clk = ~clk;

  buck_supervisor #(.DAC_W(DW), .TARGET_CODE(TGT), .STEP_CYCLES(STEP),
                    .BLANK_CYCLES(BLANK), .UV_DELAY(UVD)) i_buck_supervisor (
    .clk(clk), .rst_n(rst_n), .en_gt_low(lo), .en_gt_high(hi), .fb_over(ov),
    .fb_under(uv), .vout_over(vh), .supply_low(sl), .temp_high(th),
    .run(run), .skip_mode(skip), .ref_code(ref_code), .hs_force_off(hs_off),
    .ls_force_on(ls_on), .ls_force_off(ls_off), .discharge(dis));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  // bench model state
  int m_ref = 0, m_div = 0, m_blank = 0, m_uvc = 0;
  bit m_lat = 0;

  function automatic bit m_active();
    return lo && !sl && !th && !m_lat;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // apply inputs, compare at mid-cycle, then advance the model across the next edge
  task automatic cyc(input bit l, input bit h, input bit o, input bit u,
                     input bit v, input bit s, input bit t, input string req);
    bit a;
    @(negedge clk);
    lo = l; hi = h; ov = o; uv = u; vh = v; sl = s; th = t;
    #1;
    a = m_active();
    chk(req, "run", run, a);
    chk(req, "skip_mode", skip, a && hi);
    chk(req, "ref_code", ref_code, m_ref);
    chk(req, "hs_force_off", hs_off, !a || ov || vh);
    chk(req, "ls_force_on", ls_on, a && ov);
    chk(req, "ls_force_off", ls_off, !a);
    chk(req, "discharge", dis, !a || ov);
    // next state
    if (!lo || sl) m_lat = 0;
    else if (a && m_blank == BLANK && uv && m_uvc == UVD - 1) m_lat = 1;
    if (!a || !(m_blank == BLANK) || !uv) m_uvc = 0;
    else if (m_uvc != UVD - 1) m_uvc++;
    if (!a) m_blank = 0; else if (m_blank != BLANK) m_blank++;
    if (!a) begin m_ref = 0; m_div = 0; end
    else if (m_ref != TGT) begin
      if (m_div == STEP - 1) begin m_div = 0; m_ref++; end else m_div++;
    end
  endtask

  task automatic idle(input int n, input bit l, input bit h, input string req);
    for (int i = 0; i < n; i++) cyc(l, h, 0, 0, 0, 0, 0, req);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    int unsigned seed = 32'd1234;
    bit u_r = 0;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // reset state: disabled, discharging
    idle(3, 0, 0, "R10");
    // R1 decode: forced PWM, auto-skip, inconsistent pair
    idle(5, 1, 0, "R1");
    idle(5, 1, 1, "R1");
    idle(3, 0, 1, "R1");
    // R2 full ramp and hold
    idle(TGT * STEP + 8, 1, 1, "R2");
    chk("R2", "ref_code at target", ref_code, TGT);
    // R11 restart from zero after disable
    idle(2, 0, 0, "R11");
    idle(10, 1, 0, "R11");
    // R7 under-voltage during blanking is ignored
    idle(2, 0, 0, "R7");
    for (int i = 0; i < BLANK; i++) cyc(1, 0, 0, 1, 0, 0, 0, "R7");
    cyc(1, 0, 0, 0, 0, 0, 0, "R7");
    chk("R7", "run after blanked UV", run, 1);
    // R6 burst one short, twice
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < UVD - 1; i++) cyc(1, 0, 0, 1, 0, 0, 0, "R6");
      cyc(1, 0, 0, 0, 0, 0, 0, "R6");
    end
    chk("R6", "run after short bursts", run, 1);
    // R3 and R4 overrides
    cyc(1, 0, 1, 0, 0, 0, 0, "R3");
    cyc(1, 0, 1, 0, 1, 0, 0, "R3");
    cyc(1, 0, 0, 0, 1, 0, 0, "R4");
    cyc(1, 0, 0, 0, 0, 0, 0, "R4");
    // R5 full burst latches
    for (int i = 0; i < UVD; i++) cyc(1, 0, 0, 1, 0, 0, 0, "R5");
    idle(4, 1, 0, "R5");
    chk("R5", "discharge after latch", dis, 1);
    // R9: over-temperature does not release; lockout does
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0, 1, "R9");
    idle(3, 1, 0, "R9");
    chk("R9", "still latched after over-temp", run, 0);
    cyc(1, 0, 0, 0, 0, 1, 0, "R9");
    idle(4, 1, 0, "R9");
    chk("R9", "run after lockout release", run, 1);
    // R8 non-latched faults and recovery with ramp restart
    idle(10, 1, 1, "R8");
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, 0, 1, "R8");
    idle(6, 1, 1, "R8");
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, 1, 0, "R8");
    idle(6, 1, 1, "R8");
    // random mix
    for (int i = 0; i < 20000; i++) begin
      bit l = lo, h = hi;
      if ($urandom % 400 == 0) l = ~l;
      if ($urandom % 300 == 0) h = ~h;
      if ($urandom % 12 == 0) u_r = ~u_r;
      cyc(l, h, ($urandom % 40) == 0, u_r, ($urandom % 40) == 0,
          ($urandom % 700) == 0, ($urandom % 600) == 0, "R5");
    end
    summary();
  end
endmodule